// File: doc/BRIEF.md
# ADC Sample Format and Clamp Unit

This block sits behind a dual-channel 13-bit parallel converter. On each rising clock edge where a sample strobe is high, it takes each channel's raw word and the converter's out-of-range flag. It then produces one registered output word per channel, together with separate overrange and underrange indications. The word is shaped by a static output mode: the full 13-bit word, a 12-bit word with the lowest bit dropped, or a reduced-range 12-bit word. The reduced-range word carries a 6 dB gain, and the block keeps it from wrapping by decoding the two upper raw bits and clamping to the signed extremes.

A format input states whether the converter delivers offset binary or two's complement. The full and truncated words keep that format. The reduced-range word is always two's complement. Mode and format are static settings. They are captured only in cycles without a sample, so a change never splits a burst.

Top module: `adc_fmt_clamp`

## Requirements
- R1: After reset, `fmt_valid`, every bit of `fmt_data`, `fmt_over` and `fmt_under` are 0.
- R2: `fmt_valid` equals `smp_valid` delayed by exactly one clock. While `smp_valid` is low, `fmt_data`, `fmt_over` and `fmt_under` hold their last values whatever the raw inputs do.
- R3: `cfg_twos`=0 selects offset binary and `cfg_twos`=1 selects two's complement. The two codes differ only in the top bit, so a zero input reads 0x1000 in offset binary and 0x0000 in two's complement.
- R4: Mode 0 (full) works in offset-binary terms, which is the raw word with bit 12 inverted when `cfg_twos`=1. A sample is out of range when that value is all ones or all zeros, or when the raw flag is set. Its offset-binary bit 12 chooses overrange (1) or underrange (0). Overrange outputs the top code (0x1FFF offset binary, 0x0FFF two's complement) and underrange outputs the bottom code (0x0000 or 0x1000).
- R5: Mode 1 (truncated) places offset-binary bits 12..1 in output bits 11..0 and sets output bit 12 to 0. Bit 11 is re-inverted for two's complement. The range check passes only when all 13 bits are equal, or when the raw flag is set. Clamp codes are 0xFFF/0x000 in offset binary and 0x7FF/0x800 in two's complement.
- R6: Mode 2 (reduced range) outputs raw bits 11..0 as two's complement, with output bit 12 at 0, for either setting of `cfg_twos`. Raw bits 12,11 decode the range. With offset-binary input, 11 means over and 00 means under. With two's-complement input, 01 means over and 10 means under. Over clamps to 0x7FF and under clamps to 0x800. The raw flag is ignored in this mode.
- R7: `fmt_over` and `fmt_under` are never both high on a channel, and both are low for an in-range sample.
- R8: `cfg_mode` and `cfg_twos` are captured only on edges where `smp_valid` is low. A change made during a burst is applied after the next idle cycle. Mode code 3 behaves as mode 0.
- R9: The two channels are processed independently, so different words in the same sample give their own results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Output mode: 0 full, 1 truncated, 2 reduced range, 3 as 0 |
| cfg_twos | input | 1 | Converter format: 0 offset binary, 1 two's complement |
| smp_valid | input | 1 | Raw sample strobe |
| smp_raw | input | 26 | Raw words, channel c in bits 13c+12..13c |
| smp_oor | input | 2 | Converter out-of-range flag per channel |
| fmt_valid | output | 1 | Output sample strobe |
| fmt_data | output | 26 | Formatted words, channel c in bits 13c+12..13c |
| fmt_over | output | 2 | Overrange indication per channel |
| fmt_under | output | 2 | Underrange indication per channel |

## Verification
The hardest case to reach is a configuration change made while a burst is in progress. The new setting must stay out of the sample that immediately follows it. The bench creates this by holding the strobe high across two samples and changing the mode input between them. It checks that the second sample still carries the reduced-range clamp. It then inserts one idle cycle and confirms that the new mode applies. The reduced-range decode is exercised with all four top-bit pairs for both formats. The truncated mode is driven with a word whose top twelve bits are all ones but whose bit 0 is zero, which must not be flagged.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_TRUNC   = 2'd1,
        MODE_REDUCED = 2'd2,
        MODE_ALIAS   = 2'd3
    } fmt_mode_e;

endpackage

// File: rtl/adc_fmt_cfg.sv
module adc_fmt_cfg
    import adc_fmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       busy,
    input  logic [1:0] mode_in,
    input  logic       twos_in,
    output fmt_mode_e  mode_q,
    output logic       twos_q
);

    typedef struct packed {
        fmt_mode_e mode;
        logic      twos;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!busy) begin
            cfg_d.mode = fmt_mode_e'(mode_in);
            cfg_d.twos = twos_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_FULL, twos: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_q = cfg_q.mode;
    assign twos_q = cfg_q.twos;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(mode_q) && $stable(twos_q))); // R8

endmodule

// File: rtl/adc_fmt_lane.sv
module adc_fmt_lane
    import adc_fmt_pkg::*;
#(
    parameter int RAW_W = 13
) (
    input  fmt_mode_e        mode,
    input  logic             twos,
    input  logic [RAW_W-1:0] raw,
    input  logic             oor,
    output logic [RAW_W-1:0] data,
    output logic             over,
    output logic             under
);

    localparam int NW = RAW_W - 1;

    logic [RAW_W-1:0] ob;
    logic [RAW_W-1:0] full_ob;
    logic [NW-1:0]    trunc_ob;
    logic [1:0]       top2;
    logic             all_eq;
    logic             flag;

    assign ob     = raw ^ {twos, {NW{1'b0}}};
    assign all_eq = (&ob) | (~|ob);
    assign top2   = raw[RAW_W-1 -: 2];

    always_comb begin
        data     = '0;
        over     = 1'b0;
        under    = 1'b0;
        flag     = 1'b0;
        full_ob  = ob;
        trunc_ob = ob[RAW_W-1:1];
        case (mode)
            MODE_TRUNC: begin
                flag  = all_eq | oor;
                over  = flag & ob[RAW_W-1];
                under = flag & ~ob[RAW_W-1];
                if (over)  trunc_ob = '1;
                if (under) trunc_ob = '0;
                data = {1'b0, trunc_ob ^ {twos, {(NW-1){1'b0}}}};
            end
            MODE_REDUCED: begin
                if (twos) begin
                    over  = (top2 == 2'b01);
                    under = (top2 == 2'b10);
                end else begin
                    over  = (top2 == 2'b11);
                    under = (top2 == 2'b00);
                end
                if (over)       data = {2'b00, {(NW-1){1'b1}}};
                else if (under) data = {2'b01, {(NW-1){1'b0}}};
                else            data = {1'b0, raw[NW-1:0]};
            end
            default: begin
                flag  = all_eq | oor;
                over  = flag & ob[RAW_W-1];
                under = flag & ~ob[RAW_W-1];
                if (over)  full_ob = '1;
                if (under) full_ob = '0;
                data = full_ob ^ {twos, {NW{1'b0}}};
            end
        endcase
    end

    always_comb begin
        AST_LANE_EXCL: assert (!(over && under)); // R7
    end

endmodule

// File: rtl/adc_fmt_clamp.sv
module adc_fmt_clamp
    import adc_fmt_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int RAW_W = 13
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             cfg_mode,
    input  logic                   cfg_twos,
    input  logic                   smp_valid,
    input  logic [NCH*RAW_W-1:0]   smp_raw,
    input  logic [NCH-1:0]         smp_oor,
    output logic                   fmt_valid,
    output logic [NCH*RAW_W-1:0]   fmt_data,
    output logic [NCH-1:0]         fmt_over,
    output logic [NCH-1:0]         fmt_under
);

    typedef struct packed {
        logic                            vld;
        logic [NCH-1:0][RAW_W-1:0]       data;
        logic [NCH-1:0]                  over;
        logic [NCH-1:0]                  under;
    } out_t;

    out_t out_d, out_q;

    fmt_mode_e mode_q;
    logic      twos_q;

    logic [NCH-1:0][RAW_W-1:0] lane_data;
    logic [NCH-1:0]            lane_over;
    logic [NCH-1:0]            lane_under;

    adc_fmt_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (smp_valid),
        .mode_in (cfg_mode),
        .twos_in (cfg_twos),
        .mode_q  (mode_q),
        .twos_q  (twos_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        adc_fmt_lane #(.RAW_W(RAW_W)) u_lane (
            .mode  (mode_q),
            .twos  (twos_q),
            .raw   (smp_raw[c*RAW_W +: RAW_W]),
            .oor   (smp_oor[c]),
            .data  (lane_data[c]),
            .over  (lane_over[c]),
            .under (lane_under[c])
        );
    end

    always_comb begin
        out_d     = out_q;
        out_d.vld = smp_valid;
        if (smp_valid) begin
            out_d.data  = lane_data;
            out_d.over  = lane_over;
            out_d.under = lane_under;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign fmt_valid = out_q.vld;
    assign fmt_data  = out_q.data;
    assign fmt_over  = out_q.over;
    assign fmt_under = out_q.under;

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> fmt_valid); // R2
    AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !fmt_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> ($stable(fmt_data) && $stable(fmt_over) && $stable(fmt_under))); // R2

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
            !(fmt_over[c] && fmt_under[c])); // R7
        AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && (mode_q == MODE_TRUNC || mode_q == MODE_REDUCED))
            |=> !fmt_data[c*RAW_W + RAW_W-1]); // R5
    end

endmodule

// File: tb/adc_fmt_clamp_test.sv
module adc_fmt_clamp_test;

    localparam int NCH = 2;
    localparam int W   = 13;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     cfg_mode = 2'd0;
    logic           cfg_twos = 1'b0;
    logic           smp_valid = 1'b0;
    logic [2*W-1:0] smp_raw = '0;
    logic [1:0]     smp_oor = '0;
    logic           fmt_valid;
    logic [2*W-1:0] fmt_data;
    logic [1:0]     fmt_over;
    logic [1:0]     fmt_under;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    adc_fmt_clamp #(.NCH(NCH), .RAW_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_twos(cfg_twos),
        .smp_valid(smp_valid), .smp_raw(smp_raw), .smp_oor(smp_oor),
        .fmt_valid(fmt_valid), .fmt_data(fmt_data),
        .fmt_over(fmt_over), .fmt_under(fmt_under)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_ch(input string req, input int c, input logic [12:0] d,
                          input logic ov, input logic un);
        chk({req, " data"}, 32'(fmt_data[c*W +: W]), 32'(d));
        chk({req, " over"}, 32'(fmt_over[c]), 32'(ov));
        chk({req, " under"}, 32'(fmt_under[c]), 32'(un));
    endtask

    // Idle cycle with config, then one sample, check both channels.
    task automatic run_one(input string req, input logic [1:0] m, input logic tc,
                           input logic [12:0] r0, input logic o0,
                           input logic [12:0] r1, input logic o1,
                           input logic [12:0] e0, input logic v0, input logic u0,
                           input logic [12:0] e1, input logic v1, input logic u1);
        @(negedge clk);
        smp_valid = 1'b0;
        cfg_mode  = m;
        cfg_twos  = tc;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_raw   = {r1, r0};
        smp_oor   = {o1, o0};
        #0.1;
        chk({req, " R2 no early valid"}, 32'(fmt_valid), 32'd0);
        @(negedge clk);
        smp_valid = 1'b0;
        chk({req, " R2 valid"}, 32'(fmt_valid), 32'd1);
        chk_ch({req, " ch0"}, 0, e0, v0, u0);
        chk_ch({req, " R9 ch1"}, 1, e1, v1, u1);
    endtask

    task automatic t_reset;
        chk("R1 valid", 32'(fmt_valid), 0);
        chk("R1 data", 32'(fmt_data), 0);
        chk("R1 over", 32'(fmt_over), 0);
        chk("R1 under", 32'(fmt_under), 0);
    endtask

    task automatic t_format;
        run_one("R3 midscale", 2'd0, 1'b0, 13'h1000, 0, 13'h0FFF, 0,
                13'h1000, 0, 0, 13'h0FFF, 0, 0);
        run_one("R3 tc zero", 2'd0, 1'b1, 13'h0000, 0, 13'h1FFF, 0,
                13'h0000, 0, 0, 13'h1FFF, 0, 0);
    endtask

    task automatic t_full;
        run_one("R4 ob ends", 2'd0, 1'b0, 13'h1FFF, 0, 13'h0000, 0,
                13'h1FFF, 1, 0, 13'h0000, 0, 1);
        run_one("R4 ob flag", 2'd0, 1'b0, 13'h1234, 1, 13'h0ABC, 1,
                13'h1FFF, 1, 0, 13'h0000, 0, 1);
        run_one("R4 tc ends", 2'd0, 1'b1, 13'h0FFF, 0, 13'h1000, 0,
                13'h0FFF, 1, 0, 13'h1000, 0, 1);
        run_one("R4 tc flag", 2'd0, 1'b1, 13'h1ABC, 1, 13'h0123, 1,
                13'h1000, 0, 1, 13'h0FFF, 1, 0);
    endtask

    task automatic t_trunc;
        run_one("R5 ob near top", 2'd1, 1'b0, 13'h1FFE, 0, 13'h0001, 0,
                13'h0FFF, 0, 0, 13'h0000, 0, 0);
        run_one("R5 ob ends", 2'd1, 1'b0, 13'h1FFF, 0, 13'h0000, 0,
                13'h0FFF, 1, 0, 13'h0000, 0, 1);
        run_one("R5 tc", 2'd1, 1'b1, 13'h0FFF, 0, 13'h1234, 0,
                13'h07FF, 1, 0, 13'h091A, 0, 0);
        run_one("R5 tc under", 2'd1, 1'b1, 13'h1000, 0, 13'h0555, 1,
                13'h0800, 0, 1, 13'h07FF, 1, 0);
    endtask

    task automatic t_reduced;
        run_one("R6 ob clamp", 2'd2, 1'b0, 13'h1800, 0, 13'h0400, 0,
                13'h07FF, 1, 0, 13'h0800, 0, 1);
        run_one("R6 ob pass", 2'd2, 1'b0, 13'h1234, 1, 13'h0ABC, 0,
                13'h0234, 0, 0, 13'h0ABC, 0, 0);
        run_one("R6 tc clamp", 2'd2, 1'b1, 13'h0800, 0, 13'h1400, 0,
                13'h07FF, 1, 0, 13'h0800, 0, 1);
        run_one("R6 tc pass", 2'd2, 1'b1, 13'h0123, 0, 13'h1FFF, 1,
                13'h0123, 0, 0, 13'h0FFF, 0, 0);
    endtask

    task automatic t_alias;
        run_one("R8 mode3 as full", 2'd3, 1'b0, 13'h1FFF, 0, 13'h1000, 0,
                13'h1FFF, 1, 0, 13'h1000, 0, 0);
    endtask

    task automatic t_hold;
        logic [2*W-1:0] d0;
        logic [1:0] o0, u0;
        run_one("R2 pre hold", 2'd0, 1'b0, 13'h1FFF, 0, 13'h0000, 0,
                13'h1FFF, 1, 0, 13'h0000, 0, 1);
        d0 = fmt_data; o0 = fmt_over; u0 = fmt_under;
        smp_raw = {13'h0AAA, 13'h1555};
        smp_oor = 2'b11;
        cfg_mode = 2'd2;
        @(negedge clk);
        @(negedge clk);
        chk("R2 hold valid", 32'(fmt_valid), 0);
        chk("R2 hold data", 32'(fmt_data), 32'(d0));
        chk("R2 hold over", 32'(fmt_over), 32'(o0));
        chk("R2 hold under", 32'(fmt_under), 32'(u0));
    endtask

    task automatic t_burst;
        @(negedge clk);
        smp_valid = 1'b0;
        cfg_mode  = 2'd2;
        cfg_twos  = 1'b0;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_raw   = {13'h1000, 13'h1800};
        smp_oor   = 2'b00;
        @(negedge clk);
        chk_ch("R8 burst first", 0, 13'h07FF, 1, 0);
        cfg_mode = 2'd0;
        @(negedge clk);
        chk_ch("R8 burst change ignored", 0, 13'h07FF, 1, 0);
        chk_ch("R8 burst ch1", 1, 13'h0000, 0, 0);
        smp_valid = 1'b0;
        @(negedge clk);
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        chk_ch("R8 after idle", 0, 13'h1800, 0, 0);
        chk_ch("R8 after idle ch1", 1, 13'h1000, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_format();
        t_full();
        t_trunc();
        t_reduced();
        t_alias();
        t_hold();
        t_burst();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule